// File: doc/BRIEF.md
# Character display power-on initializer

This block runs the software reset and setup sequence that a character dot-matrix display module needs after power-up. It works in either an 8-bit or a 4-bit bus mode. It does not drive the display pins itself. Each write goes to a separate bus cycle engine, which takes a request, returns a one-cycle acknowledge once the transfer is complete, and handles the pin timing.

Between writes the block counts out fixed waits, given as parameters in clock cycles, so it never polls the busy flag. The steps are: a power-up delay, three reset nibbles and, in 4-bit mode, one nibble that switches the width. Four full instructions follow: function set, display off, clear, and entry mode. A fifth instruction that turns the display on can be enabled by a parameter.

When the last wait expires, `boot_done` rises and stays high. From then on the host's request, register select and byte pass straight through to the engine, and the engine's acknowledge goes back to the host. Until then, host requests are not forwarded and are never acknowledged.

Top module: `charpanel_boot`

## Requirements
- R1: After reset release, `bus_req` stays low for exactly PWR_CYC clock cycles, and `boot_done` is low throughout this time.
- R2: The first three writes are single-nibble writes (`bus_half`=1, `bus_rs`=0) of byte 30h. The waits after them are GAP1_CYC, GAP2_CYC and CMD_CYC cycles, counted from the acknowledge cycle to the next request.
- R3: When NIBBLE_BUS=1, a fourth single-nibble write of 20h follows, with a CMD_CYC wait after it. When NIBBLE_BUS=0, this write does not occur. Every single-nibble write carries zero in bits 3..0.
- R4: The next write is a full-byte (`bus_half`=0) function set: 20h, plus 10h when NIBBLE_BUS=0, plus 08h when TWO_ROWS=1, plus 04h when TALL_FONT=1.
- R5: Then come full-byte instructions (`bus_rs`=0) 08h, 01h and 06h, in that order. The wait after 01h is CLR_CYC cycles, and every other wait is CMD_CYC cycles.
- R6: When LIGHT_UP=1, a final full-byte instruction 0Ch follows 06h. When LIGHT_UP=0, the sequence ends at 06h.
- R7: Once raised, a request stays high with unchanged byte and nibble flag until the cycle in which `bus_ack` is seen. Each acknowledged step is issued once.
- R8: `boot_done` rises exactly when the wait after the last step expires (no request in the cycle before) and then stays high.
- R9: While `boot_done` is low, `host_req` has no effect on the bus and `host_ack` stays low. Once `boot_done` is high, the engine receives the host's request, register select and byte as a full-byte write, and `host_ack` follows `bus_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | output | 1 | Write request to the bus cycle engine |
| bus_rs | output | 1 | Register select: 0 instruction, 1 data |
| bus_half | output | 1 | 1: send only the upper nibble of `bus_byte` once |
| bus_byte | output | 8 | Byte to write |
| bus_ack | input | 1 | One-cycle acknowledge from the engine |
| host_req | input | 1 | Host write request, used after `boot_done` |
| host_rs | input | 1 | Host register select |
| host_byte | input | 8 | Host byte |
| host_ack | output | 1 | Acknowledge returned to the host |
| boot_done | output | 1 | Sequence complete; bus belongs to the host |

## Verification
The bench sweeps four configurations that cover both bus widths, the optional display-on step, both fonts and both line counts. It compares every logged write, and the exact idle gap before each write, against a sequence computed from the parameters.

Several faults would show up in these checks:
- A wrong data-length bit, or a mode nibble sent in 8-bit mode, would put a wrong byte or an extra entry in the log.
- Using the command wait after the clear would shorten one gap.
- An off-by-one in the wait counter would shift every gap by one.

The host holds its request high from the start with a data byte. A design that leaks the host onto the bus early would log that byte inside the sequence, or acknowledge the host before `boot_done`.

// File: rtl/charpanel_boot.sv
module charpanel_boot #(
  parameter bit NIBBLE_BUS = 1'b1,
  parameter bit TALL_FONT  = 1'b0,
  parameter bit TWO_ROWS   = 1'b1,
  parameter bit LIGHT_UP   = 1'b1,
  parameter int unsigned PWR_CYC  = 1875000,
  parameter int unsigned GAP1_CYC = 512500,
  parameter int unsigned GAP2_CYC = 12500,
  parameter int unsigned CMD_CYC  = 5000,
  parameter int unsigned CLR_CYC  = 205000
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       bus_req,
  output logic       bus_rs,
  output logic       bus_half,
  output logic [7:0] bus_byte,
  input  logic       bus_ack,
  input  logic       host_req,
  input  logic       host_rs,
  input  logic [7:0] host_byte,
  output logic       host_ack,
  output logic       boot_done
);
  localparam int unsigned BIG_A = (PWR_CYC > GAP1_CYC) ? PWR_CYC : GAP1_CYC;
  localparam int unsigned BIG_B = (CLR_CYC > GAP2_CYC) ? CLR_CYC : GAP2_CYC;
  localparam int unsigned BIG_C = (BIG_A > BIG_B) ? BIG_A : BIG_B;
  localparam int unsigned BIG   = (BIG_C > CMD_CYC) ? BIG_C : CMD_CYC;
  localparam int CW = $clog2(BIG + 1);
  localparam logic [3:0] LAST = LIGHT_UP ? 4'd8 : 4'd7;
  localparam logic [7:0] FSET = 8'h20 | (NIBBLE_BUS ? 8'h00 : 8'h10)
                              | (TWO_ROWS ? 8'h08 : 8'h00) | (TALL_FONT ? 8'h04 : 8'h00);

  typedef enum logic [1:0] {WAITING, ISSUE, HANDOFF} phase_t;

  phase_t        phase;
  logic [3:0]    step;
  logic [CW-1:0] cnt;
  logic          fin;
  logic [7:0]    step_byte;
  logic [CW-1:0] step_gap;

  always_comb begin
    case (step)
      4'd0, 4'd1, 4'd2: step_byte = 8'h30;
      4'd3:             step_byte = 8'h20;
      4'd4:             step_byte = FSET;
      4'd5:             step_byte = 8'h08;
      4'd6:             step_byte = 8'h01;
      4'd7:             step_byte = 8'h06;
      default:          step_byte = 8'h0C;
    endcase
    case (step)
      4'd0:    step_gap = CW'(GAP1_CYC - 1);
      4'd1:    step_gap = CW'(GAP2_CYC - 1);
      4'd6:    step_gap = CW'(CLR_CYC - 1);
      default: step_gap = CW'(CMD_CYC - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= WAITING;
      cnt   <= CW'(PWR_CYC);
      step  <= 4'd0;
      fin   <= 1'b0;
    end else begin
      case (phase)
        WAITING:
          if (cnt == '0) phase <= fin ? HANDOFF : ISSUE;
          else           cnt   <= cnt - 1'b1;
        ISSUE:
          if (bus_ack) begin
            cnt   <= step_gap;
            fin   <= (step == LAST);
            step  <= (step == 4'd2 && !NIBBLE_BUS) ? 4'd4 : step + 4'd1;
            phase <= WAITING;
          end
        default: phase <= HANDOFF;
      endcase
    end
  end

  assign boot_done = (phase == HANDOFF);
  assign bus_req   = boot_done ? host_req  : (phase == ISSUE);
  assign bus_rs    = boot_done & host_rs;
  assign bus_half  = !boot_done && (step <= 4'd3);
  assign bus_byte  = boot_done ? host_byte : step_byte;
  assign host_ack  = boot_done & bus_ack;
endmodule

module charpanel_boot_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_req,
  input logic       bus_rs,
  input logic       bus_half,
  input logic [7:0] bus_byte,
  input logic       bus_ack,
  input logic       host_ack,
  input logic       boot_done
);
  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack && !boot_done) |=> (bus_req && $stable(bus_byte) && $stable(bus_half)));
  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> boot_done);
  // R8
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(boot_done) |-> !$past(bus_req));
  // R9
  host_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_done |-> !host_ack);
  // R3
  half_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_half) |-> (!bus_rs && bus_byte[3:0] == 4'h0));
  // R5
  seq_instr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !boot_done) |-> !bus_rs);
endmodule

bind charpanel_boot charpanel_boot_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_rs(bus_rs), .bus_half(bus_half),
  .bus_byte(bus_byte), .bus_ack(bus_ack), .host_ack(host_ack), .boot_done(boot_done));

// File: tb/charpanel_boot_tb.sv
module charpanel_boot_tb_top;
  localparam int P  = 20;
  localparam int G1 = 12;
  localparam int G2 = 5;
  localparam int GC = 3;
  localparam int GK = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int checks = 0;
  int errors = 0;
  logic [3:0] cfg_fin = '0;

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  for (genvar g = 0; g < 4; g++) begin : cfg
    localparam bit B4 = (g % 2) == 1;
    localparam bit LU = (g / 2) == 1;
    localparam bit FT = (g == 1 || g == 2);
    localparam bit TR = (g == 0 || g == 3);
    localparam int NSEQ = 7 + (B4 ? 1 : 0) + (LU ? 1 : 0);

    logic       bus_req, bus_rs, bus_half, host_ack, boot_done;
    logic [7:0] bus_byte;
    logic       rdy;
    int n, lowcnt, wc, leak;
    logic [7:0] lg_byte [16];
    logic       lg_rs [16], lg_half [16], lg_done [16], lg_hack [16];
    int         lg_gap [16];

    charpanel_boot #(.NIBBLE_BUS(B4), .TALL_FONT(FT), .TWO_ROWS(TR), .LIGHT_UP(LU),
      .PWR_CYC(P), .GAP1_CYC(G1), .GAP2_CYC(G2), .CMD_CYC(GC), .CLR_CYC(GK)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_rs(bus_rs), .bus_half(bus_half),
      .bus_byte(bus_byte), .bus_ack(rdy), .host_req(1'b1), .host_rs(1'b1),
      .host_byte(8'hA5), .host_ack(host_ack), .boot_done(boot_done));

    always @(negedge clk) begin
      if (!rst_n) begin
        rdy = 1'b0; n = 0; lowcnt = 0; wc = 0; leak = 0;
      end else begin
        if (!bus_req) lowcnt++;
        if (!boot_done && host_ack) leak++;
        if (rdy) begin
          lg_hack[n-1] = host_ack;
          rdy = 1'b0;
        end else if (bus_req && n < 16) begin
          if (wc >= n % 3) begin
            lg_byte[n] = bus_byte; lg_rs[n] = bus_rs; lg_half[n] = bus_half;
            lg_done[n] = boot_done; lg_gap[n] = lowcnt;
            lowcnt = 0; wc = 0; n++; rdy = 1'b1;
          end else wc++;
        end
      end
    end

    function automatic logic [7:0] exp_byte(int k);
      int j;
      if (k < 3) return 8'h30;
      if (B4 && k == 3) return 8'h20;
      j = k - 3 - (B4 ? 1 : 0);
      case (j)
        0: return 8'h20 | (B4 ? 8'h00 : 8'h10) | (TR ? 8'h08 : 8'h00) | (FT ? 8'h04 : 8'h00);
        1: return 8'h08;
        2: return 8'h01;
        3: return 8'h06;
        default: return 8'h0C;
      endcase
    endfunction

    function automatic int exp_gap(int k);
      if (k == 0) return P;
      if (k == 1) return G1;
      if (k == 2) return G2;
      if (exp_byte(k - 1) == 8'h01 && k - 1 >= 3) return GK;
      return GC;
    endfunction

    initial begin
      @(negedge clk);
      chk(bus_req == 1'b0 && boot_done == 1'b0, $sformatf("R1 cfg%0d reset state", g), {bus_req, boot_done}, 0);
      while (n < NSEQ + 2) @(negedge clk);
      @(negedge clk);
      for (int k = 0; k < NSEQ; k++) begin
        string rq;
        rq = (k < 3) ? "R2" : (k == 3 && B4) ? "R3" : (k == 3 + (B4 ? 1 : 0)) ? "R4" :
             (k == NSEQ - 1 && LU) ? "R6" : "R5";
        chk(lg_byte[k] == exp_byte(k), $sformatf("%s cfg%0d step%0d byte", rq, g, k), lg_byte[k], exp_byte(k));
        chk(lg_half[k] == (k < 3 + (B4 ? 1 : 0)), $sformatf("%s cfg%0d step%0d half", rq, g, k), lg_half[k], k < 3 + (B4 ? 1 : 0));
        chk(lg_rs[k] == 1'b0, $sformatf("R9 cfg%0d step%0d rs while host requests", g, k), lg_rs[k], 0);
        chk(lg_gap[k] == exp_gap(k), $sformatf("%s cfg%0d step%0d gap (R1 for step0)", rq, g, k), lg_gap[k], exp_gap(k));
        chk(lg_done[k] == 1'b0 && lg_hack[k] == 1'b0, $sformatf("R9 cfg%0d step%0d done/host_ack", g, k), {lg_done[k], lg_hack[k]}, 0);
      end
      chk(lg_gap[NSEQ] == exp_gap(NSEQ), $sformatf("R8 cfg%0d done delay", g), lg_gap[NSEQ], exp_gap(NSEQ));
      chk(lg_done[NSEQ] && lg_byte[NSEQ] == 8'hA5 && lg_rs[NSEQ] && !lg_half[NSEQ],
          $sformatf("R9 cfg%0d host pass-through", g), {lg_done[NSEQ], lg_byte[NSEQ]}, 9'h1A5);
      chk(lg_hack[NSEQ] == 1'b1 && lg_hack[NSEQ+1] == 1'b1, $sformatf("R9 cfg%0d host_ack", g), {lg_hack[NSEQ], lg_hack[NSEQ+1]}, 3);
      chk(lg_gap[NSEQ+1] == 0 && boot_done, $sformatf("R8 cfg%0d done held", g), {lg_gap[NSEQ+1], boot_done}, 1);
      chk(leak == 0, $sformatf("R9 cfg%0d early host_ack", g), leak, 0);
      chk(n == NSEQ + 2 || lg_byte[n-1] == 8'hA5, $sformatf("R7 cfg%0d no repeated step", g), lg_byte[n-1], 8'hA5);
      cfg_fin[g] = 1'b1;
    end
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    cyc = 0;
    while (cfg_fin != 4'hF && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    #1;
    if (cfg_fin != 4'hF) begin
      checks++;
      errors++;
      $display("FAIL watchdog R8 actual=%0h expected=%0h", cfg_fin, 4'hF);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule